// File: doc/BRIEF.md
# Multi-Channel Fan Tachometer Monitor

This block watches the tachometer outputs of up to sixteen fans (twelve by default) and measures the time between successive rising edges on each one. The time is counted in ticks of a reference clock, which is the module clock divided by a parameter. Each result is a 13-bit count. A long period means a slow fan. Two count values are reserved to mean the fan is not turning: zero, and the saturated value 0x1FFF. Firmware converts a count to speed by dividing a fixed constant by the count, with one tach pulse per revolution.

Each channel has a programmable low-speed limit. The block compares every new count with that limit. When a fan is too slow, or has stopped, the block raises a sticky alarm bit in a packed status byte. Reading a status byte returns its alarms and clears them. An enable mask selects which inputs are measured.

All state is reached through a byte-wide register port. Reads return data one cycle after the read strobe.

Top module: `fan_tach_monitor`

## Requirements
- R1: Each enabled channel counts reference ticks. Every rising tach edge, after a two-flop synchronizer, latches the ticks counted since the previous rising edge. With a divider of 1, a tach square wave of period P clock cycles reads P. The first edge after enabling only starts the count and latches nothing.
- R2: The count of channel n is split across two registers. Address 2n returns count bits 12:5. Address 2n+1 returns bits 4:0 in data bits 4:0, with data bits 7:5 read as zero.
- R3: A read of address 2n captures the low five bits of channel n's count. Every read of any address 2n+1 returns the bits captured by the most recent even-address count read, even if the count has changed since then.
- R4: Each channel's limit uses the same split. Address 0x20+2n holds bits 12:5 and address 0x21+2n holds bits 4:0. Both are writable and read back as written. A limit resets to 0x1FFF.
- R5: An alarm is raised when a newly latched count is greater than the channel's limit. A count equal to the limit raises no alarm.
- R6: If no edge arrives, the count saturates at 0x1FFF. The register then reads 0x1FFF and the channel raises an alarm once.
- R7: The alarm of channel n is bit n mod 8 of the status byte at address 0x40 + n/8. Status bits stay set until read, and bits with no channel read as zero.
- R8: Reading a status byte returns its pending alarms and clears them. An alarm raised in the same cycle as the read survives the read.
- R9: The enable mask is at 0x48 (channels 7:0) and 0x49 (channels 15:8), and resets to zero. A disabled channel reads a count of 0 and raises no alarm.
- R10: Read data is registered. It changes only in the cycle after a read strobe and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module and reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tach | input | NUM_FANS | Raw tachometer inputs, asynchronous |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after rd_en |

## Verification
The bench aims at the count boundaries: a count exactly equal to the limit and one tick above it. A comparison written as greater-or-equal, or as the wrong direction, shows up as a wrong alarm bit.

It lets every fan stall until the counter saturates. It then checks that the count reads 0x1FFF and that each alarm appears exactly once, so that a second status read returns zero. A design that kept re-raising the alarm, or never cleared it, would fail the second read.

The bench also changes a fan's period between reading the high and low count bytes. A design without the snapshot would return low bits of the new count. Finally, some channels are masked off while all fans are stalled. A design that leaks alarms from masked channels would set their status bits.

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;
   // register map bases (byte addresses)
   localparam int unsigned CNT_BASE  = 'h00;  // count hi at 2n, lo at 2n+1
   localparam int unsigned LIM_BASE  = 'h20;  // limit hi at 2n, lo at 2n+1
   localparam int unsigned STAT_BASE = 'h40;  // packed alarm bytes
   localparam int unsigned EN_BASE   = 'h48;  // enable mask, two bytes
   localparam int unsigned MASK_W    = 16;
endpackage

// File: rtl/fan_tach_chan.sv
module fan_tach_chan #(
   parameter int CNT_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             enable,
   input  logic             tach_in,
   input  logic [CNT_W-1:0] limit,
   output logic [CNT_W-1:0] period,
   output logic             alarm_set
);
   localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

   logic [1:0]       sync_q;
   logic             prev_q;
   logic             armed_q;
   logic [CNT_W-1:0] cnt_q;
   logic             rise;
   logic             upd;
   logic [CNT_W-1:0] new_val;
   logic             bad;

   assign rise = sync_q[1] & ~prev_q;

   always_comb begin
      upd     = 1'b0;
      new_val = period;
      if (rise && armed_q) begin
         upd     = 1'b1;
         new_val = cnt_q;
      end else if (cnt_q == CMAX && period != CMAX) begin
         upd     = 1'b1;
         new_val = CMAX;
      end
      bad = (new_val == '0) || (new_val == CMAX) || (new_val > limit);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q    <= '0;
         prev_q    <= 1'b0;
         armed_q   <= 1'b0;
         cnt_q     <= '0;
         period    <= '0;
         alarm_set <= 1'b0;
      end else begin
         sync_q <= {sync_q[0], tach_in};
         prev_q <= sync_q[1];
         if (!enable) begin
            armed_q   <= 1'b0;
            cnt_q     <= '0;
            period    <= '0;
            alarm_set <= 1'b0;
         end else begin
            alarm_set <= upd & bad;
            if (upd) period <= new_val;
            if (rise) begin
               armed_q <= 1'b1;
               cnt_q   <= tick ? CNT_W'(1) : '0;
            end else if (tick && cnt_q != CMAX) begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/fan_tach_status.sv
module fan_tach_status #(
   parameter int NUM_FANS = 12,
   parameter int NBYTES   = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_FANS-1:0] set_bits,
   input  logic [NBYTES-1:0]   clr_byte,
   output logic [NBYTES*8-1:0] stat
);
   for (genvar i = 0; i < NBYTES*8; i++) begin : g_bit
      if (i < NUM_FANS) begin : g_live
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stat[i] <= 1'b0;
            else        stat[i] <= set_bits[i] | (stat[i] & ~clr_byte[i/8]);
         end
      end else begin : g_pad
         assign stat[i] = 1'b0;
      end
   end
endmodule

// File: rtl/fan_tach_monitor.sv
module fan_tach_monitor
   import fan_tach_pkg::*;
#(
   parameter int NUM_FANS = 12,
   parameter int CNT_W    = 13,
   parameter int ADDR_W   = 8,
   parameter int TICK_DIV = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_FANS-1:0] tach,
   input  logic                wr_en,
   input  logic                rd_en,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [7:0]          wdata,
   output logic [7:0]          rdata
);
   localparam int LOW_W  = CNT_W - 8;
   localparam int NBYTES = (NUM_FANS + 7) / 8;

   if (NUM_FANS < 1 || NUM_FANS > MASK_W) begin : g_bad_fans
      $error("NUM_FANS must be 1..16");
   end
   if (CNT_W <= 8 || CNT_W > 16) begin : g_bad_cnt
      $error("CNT_W must be 9..16");
   end
   if (ADDR_W < 7) begin : g_bad_addr
      $error("ADDR_W too small for map");
   end
   if (TICK_DIV < 1) begin : g_bad_div
      $error("TICK_DIV must be positive");
   end

   // reference tick
   logic tick;
   if (TICK_DIV == 1) begin : g_tick_full
      assign tick = 1'b1;
   end else begin : g_tick_div
      localparam int DW = $clog2(TICK_DIV);
      logic [DW-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                         div_q <= '0;
         else if (div_q == DW'(TICK_DIV-1)) div_q <= '0;
         else                                div_q <= div_q + 1'b1;
      end
      assign tick = (div_q == DW'(TICK_DIV-1));
   end

   logic [MASK_W-1:0] en_mask;
   logic [CNT_W-1:0]  lim    [NUM_FANS];
   logic [CNT_W-1:0]  period [NUM_FANS];
   logic [NUM_FANS-1:0] alarm_set;
   logic [NBYTES*8-1:0] stat;
   logic [NBYTES-1:0]   clr_byte;
   logic [LOW_W-1:0]    snap, snap_nxt;
   logic [7:0]          rd_mux;

   for (genvar n = 0; n < NUM_FANS; n++) begin : g_ch
      fan_tach_chan #(.CNT_W(CNT_W)) u_chan (
         .clk(clk), .rst_n(rst_n), .tick(tick), .enable(en_mask[n]),
         .tach_in(tach[n]), .limit(lim[n]), .period(period[n]),
         .alarm_set(alarm_set[n])
      );
   end

   fan_tach_status #(.NUM_FANS(NUM_FANS), .NBYTES(NBYTES)) u_stat (
      .clk(clk), .rst_n(rst_n), .set_bits(alarm_set), .clr_byte(clr_byte),
      .stat(stat)
   );

   // writes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_mask <= '0;
         for (int n = 0; n < NUM_FANS; n++) lim[n] <= {CNT_W{1'b1}};
      end else if (wr_en) begin
         if (addr == ADDR_W'(EN_BASE))     en_mask[7:0]  <= wdata;
         if (addr == ADDR_W'(EN_BASE + 1)) en_mask[15:8] <= wdata;
         for (int n = 0; n < NUM_FANS; n++) begin
            if (addr == ADDR_W'(LIM_BASE + 2*n))
               lim[n][CNT_W-1:LOW_W] <= wdata[CNT_W-LOW_W-1:0];
            if (addr == ADDR_W'(LIM_BASE + 2*n + 1))
               lim[n][LOW_W-1:0] <= wdata[LOW_W-1:0];
         end
      end
   end

   // read decode
   always_comb begin
      rd_mux   = '0;
      snap_nxt = snap;
      clr_byte = '0;
      if (addr == ADDR_W'(EN_BASE))     rd_mux = en_mask[7:0];
      if (addr == ADDR_W'(EN_BASE + 1)) rd_mux = en_mask[15:8];
      for (int n = 0; n < NUM_FANS; n++) begin
         if (addr == ADDR_W'(CNT_BASE + 2*n)) begin
            rd_mux   = 8'(period[n][CNT_W-1:LOW_W]);
            snap_nxt = period[n][LOW_W-1:0];
         end
         if (addr == ADDR_W'(CNT_BASE + 2*n + 1))
            rd_mux = 8'(snap);
         if (addr == ADDR_W'(LIM_BASE + 2*n))
            rd_mux = 8'(lim[n][CNT_W-1:LOW_W]);
         if (addr == ADDR_W'(LIM_BASE + 2*n + 1))
            rd_mux = 8'(lim[n][LOW_W-1:0]);
      end
      for (int k = 0; k < NBYTES; k++) begin
         if (addr == ADDR_W'(STAT_BASE + k)) begin
            rd_mux      = stat[k*8 +: 8];
            clr_byte[k] = rd_en;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
         snap  <= '0;
      end else if (rd_en) begin
         rdata <= rd_mux;
         snap  <= snap_nxt;
      end
   end
endmodule

// File: rtl/fan_tach_monitor_chk.sv
module fan_tach_monitor_chk
   import fan_tach_pkg::*;
#(
   parameter int NUM_FANS = 12,
   parameter int CNT_W    = 13,
   parameter int ADDR_W   = 8,
   parameter int NBYTES   = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                rd_en,
   input logic                wr_en,
   input logic [ADDR_W-1:0]   addr,
   input logic [7:0]          rdata,
   input logic [15:0]         en_mask,
   input logic [NUM_FANS-1:0] alarm_set,
   input logic [NBYTES*8-1:0] stat,
   input logic [CNT_W-1:0]    per0,
   input logic [CNT_W-9:0]    snap
);
   localparam int B0 = (NUM_FANS < 8) ? NUM_FANS : 8;
   logic stat_rd0;
   assign stat_rd0 = rd_en && (addr == ADDR_W'(STAT_BASE));

   p_snap_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && addr == ADDR_W'(CNT_BASE)) |=> (snap == $past(per0[CNT_W-9:0])));

   p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (stat[0] && !stat_rd0) |=> stat[0]);

   p_rd_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd0 && alarm_set[B0-1:0] == '0) |=> (stat[7:0] == 8'h00));

   p_mask_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((alarm_set & ~$past(en_mask[NUM_FANS-1:0])) == '0));

   p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));
endmodule

bind fan_tach_monitor fan_tach_monitor_chk #(
   .NUM_FANS(NUM_FANS), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .NBYTES(NBYTES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
   .rdata(rdata), .en_mask(en_mask), .alarm_set(alarm_set), .stat(stat),
   .per0(period[0]), .snap(snap)
);

// File: tb/fan_tach_monitor_test.sv
`timescale 1ns/1ps
module fan_tach_monitor_test;
   localparam int NF = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NF-1:0] tach = '0;
   logic          wr_en = 1'b0;
   logic          rd_en = 1'b0;
   logic [7:0]    addr = '0;
   logic [7:0]    wdata = '0;
   logic [7:0]    rdata;

   int n_chk = 0;
   int n_bad = 0;
   int per_cfg [NF];
   int phase   [NF];
   bit done = 0;

   always #2.5 clk = ~clk;

   fan_tach_monitor #(.NUM_FANS(NF), .CNT_W(13), .ADDR_W(8), .TICK_DIV(1)) uut (
      .clk(clk), .rst_n(rst_n), .tach(tach), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata)
   );

   // tach generator: square wave of per_cfg[n] cycles, 0 = stalled low
   always @(negedge clk) begin
      for (int n = 0; n < NF; n++) begin
         if (per_cfg[n] == 0) begin
            phase[n] = 0;
            tach[n] <= 1'b0;
         end else begin
            phase[n] = (phase[n] + 1) % per_cfg[n];
            tach[n] <= (phase[n] < per_cfg[n] / 2);
         end
      end
   end

   function automatic logic [7:0] hi_of(int c);
      return 8'((c >> 5) & 'hFF);
   endfunction
   function automatic logic [7:0] lo_of(int c);
      return 8'(c & 'h1F);
   endfunction

   task automatic check(string req, logic [7:0] got, logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %02h expected %02h", req, got, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [7:0] d);
      @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, output logic [7:0] d);
      @(negedge clk); rd_en = 1'b1; addr = a;
      @(negedge clk); rd_en = 1'b0; d = rdata;
   endtask

   task automatic wait_cyc(int k);
      repeat (k) @(negedge clk);
   endtask

   task automatic set_lim(int n, int v);
      wr(8'('h20 + 2*n), hi_of(v));
      wr(8'('h21 + 2*n), lo_of(v));
   endtask

   initial begin
      #(5.0 * 190000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] d, d2;
      int lim_cfg [NF];
      logic [15:0] exp_al;
      void'($urandom(32'd4321));
      for (int n = 0; n < NF; n++) begin per_cfg[n] = 0; phase[n] = 0; end
      wait_cyc(4);
      rst_n = 1'b1;
      wait_cyc(2);

      // reset state
      rd(8'h00, d); check("R2 reset count hi", d, 8'h00);
      rd(8'h20, d); check("R4 reset limit hi", d, 8'hFF);
      rd(8'h21, d); check("R4 reset limit lo", d, 8'h1F);
      rd(8'h40, d); check("R7 reset status", d, 8'h00);
      rd(8'h48, d); check("R9 reset enable", d, 8'h00);

      // limit write/readback
      set_lim(5, 'h1234);
      rd(8'h2A, d); check("R4 limit hi", d, hi_of('h1234));
      rd(8'h2B, d); check("R4 limit lo", d, lo_of('h1234));

      // random periods with directed equal/over-by-one boundary
      for (int n = 0; n < NF; n++) begin
         per_cfg[n] = 40 + int'($urandom_range(560));
         lim_cfg[n] = 40 + int'($urandom_range(560));
      end
      per_cfg[0] = 100; lim_cfg[0] = 100;
      per_cfg[1] = 101; lim_cfg[1] = 100;
      wr(8'h48, 8'hFF); wr(8'h49, 8'hFF);
      rd(8'h49, d); check("R9 enable readback", d, 8'hFF);
      wait_cyc(1500);
      for (int n = 0; n < NF; n++) begin
         rd(8'(2*n), d); rd(8'(2*n + 1), d2);
         check("R1 count hi", d, hi_of(per_cfg[n]));
         check("R2 count lo", d2, lo_of(per_cfg[n]));
      end
      for (int n = 0; n < NF; n++) set_lim(n, lim_cfg[n]);
      wait_cyc(1500);
      rd(8'h40, d); rd(8'h41, d);
      wait_cyc(1500);
      exp_al = '0;
      for (int n = 0; n < NF; n++) exp_al[n] = (per_cfg[n] > lim_cfg[n]);
      rd(8'h40, d); check("R5 alarms byte0", d, exp_al[7:0]);
      rd(8'h41, d); check("R5 alarms byte1", d, exp_al[15:8]);

      // snapshot coherence on channel 2
      per_cfg[2] = 200;
      wait_cyc(1000);
      rd(8'h04, d); check("R3 hi before change", d, hi_of(200));
      per_cfg[2] = 333;
      wait_cyc(2000);
      rd(8'h05, d); check("R3 lo from snapshot", d, lo_of(200));
      rd(8'h04, d); check("R3 hi after change", d, hi_of(333));
      rd(8'h05, d); check("R3 lo after change", d, lo_of(333));

      // stall all fans: saturation and single alarm
      for (int n = 0; n < NF; n++) set_lim(n, 'h1FFF);
      for (int n = 0; n < NF; n++) per_cfg[n] = 0;
      wait_cyc(9000);
      rd(8'h06, d); rd(8'h07, d2);
      check("R6 stalled hi", d, 8'hFF);
      check("R6 stalled lo", d2, 8'h1F);
      rd(8'h40, d); check("R6 stall alarms byte0", d, 8'hFF);
      rd(8'h41, d); check("R7 stall alarms byte1 pad", d, 8'h0F);
      rd(8'h40, d); check("R8 cleared byte0", d, 8'h00);
      rd(8'h41, d); check("R8 cleared byte1", d, 8'h00);

      // masked channels 0 and 9
      wr(8'h48, 8'h00); wr(8'h49, 8'h00);
      wait_cyc(4);
      rd(8'h40, d); rd(8'h41, d);
      wr(8'h48, 8'hFE); wr(8'h49, 8'h0D);
      wait_cyc(9000);
      rd(8'h40, d); check("R9 masked byte0", d, 8'hFE);
      rd(8'h41, d); check("R9 masked byte1", d, 8'h0D);
      rd(8'h00, d); check("R9 disabled count", d, 8'h00);
      rd(8'h48, d); check("R9 mask readback", d, 8'hFE);

      // rdata holds without a strobe
      rd(8'h2A, d);
      wait_cyc(3);
      check("R10 rdata hold", rdata, d);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule